// File: doc/BRIEF.md
# Center-Aligned Complementary PWM Pair

This block drives one power half-bridge with a high-side output and a low-side output. The outputs are complementary and active low. A counter steps up across the first half of the PWM period and back down across the second half, so each switching edge mirrors about the midpoint of the period. One period takes twice the value `period_i`, counted in clock ticks.

The duty input is a signed two's-complement offset from the 50% point. The ideal switching instant in each half sits at count `floor(P/2) - D`, where P is the half-period count and D is the duty value. The dead-time value then moves the high side's turn-on edge later by DT ticks and the low side's turn-off edge earlier by DT ticks. The high-side pulse shrinks by the same amount at both ends of the period, and so does the low-side pulse, so both stay centered.

Period, duty and dead time are captured at the start of each period. Those same values then shape both halves. A phase status output reports which half is running.

Top module: `cpwm_pair`

## Requirements
- R1: While reset is asserted, both outputs are high (switch off) and `phase_o` is 0.
- R2: One cycle after `en` rises with a non-zero period P, a period begins. Each period lasts 2·P cycles. `phase_o` is 0 for the first P cycles and 1 for the next P cycles. Periods then repeat back to back.
- R3: Let tick k run from 0 to 2P-1 within a period. The position is pos = k for k < P and pos = 2P-1-k otherwise. `hi_n_o` is low exactly when pos ≥ floor(P/2) − D + DT. With D = 0 and DT = 0 the high side is on for half the period.
- R4: `lo_n_o` is low exactly when pos < floor(P/2) − D − DT.
- R5: `hi_n_o` and `lo_n_o` are never low in the same cycle.
- R6: If D ≥ floor(P/2) + DT, the high side is on for every tick of the period and the low side never turns on. If D ≤ −(P − floor(P/2)) − DT, the low side is on for every tick and the high side never turns on.
- R7: A change of `period_i`, `duty_i` or `dead_i` during a period has no effect until the next period starts.
- R8: While `en` is 0 or `period_i` is 0, starting one cycle later, both outputs are high and `phase_o` is 0. The next enable restarts a period from tick 0.
- R9: Each output's value at tick k equals its value at tick 2P-1-k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock; all counts are in its ticks |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable |
| period_i | input | W | Half-period length P in ticks |
| duty_i | input | W+1 | Signed duty offset D; 0 gives 50% |
| dead_i | input | W | Dead-time DT in ticks |
| hi_n_o | output | 1 | High-side drive, low = on |
| lo_n_o | output | 1 | Low-side drive, low = on |
| phase_o | output | 1 | 0 in the first half of the period, 1 in the second |

## Verification
The hardest case to reach from the ports is a duty change that arrives in the middle of a period. The design must ignore it until the counter returns to zero. To reach that case, the bench writes a new duty exactly at the midpoint tick, where the phase flips. It checks the rest of that period against the old value and the next period against the new one. The saturation limits, with dead time folded in, also need deliberate stimulus. The bench drives duty values just past each limit and counts on-ticks over whole periods.

// File: rtl/cpwm_pair.sv
module cpwm_pair #(
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [W-1:0]        period_i,
  input  logic signed [W:0]   duty_i,
  input  logic [W-1:0]        dead_i,
  output logic                hi_n_o,
  output logic                lo_n_o,
  output logic                phase_o
);
  localparam int XW = W + 3;

  logic              run, ph;
  logic [W-1:0]      pos, per_r, dead_r;
  logic signed [W:0] duty_r;

  wire hold  = !en || (period_i == '0);
  wire start = !run || (ph && pos == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      ph     <= 1'b0;
      pos    <= '0;
      per_r  <= '0;
      dead_r <= '0;
      duty_r <= '0;
    end else if (hold) begin
      run <= 1'b0;
      ph  <= 1'b0;
      pos <= '0;
    end else if (start) begin
      run    <= 1'b1;
      ph     <= 1'b0;
      pos    <= '0;
      per_r  <= period_i;
      dead_r <= dead_i;
      duty_r <= duty_i;
    end else if (!ph) begin
      if (pos == per_r - 1'b1) ph <= 1'b1;
      else                      pos <= pos + 1'b1;
    end else begin
      pos <= pos - 1'b1;
    end
  end

  logic signed [XW-1:0] mid_s, duty_s, dt_s, pos_s, edge_s, hi_th, lo_th;
  logic                 hi_on, lo_on;

  assign mid_s  = $signed({{(XW-W){1'b0}}, per_r >> 1});
  assign duty_s = $signed({{(XW-W-1){duty_r[W]}}, duty_r});
  assign dt_s   = $signed({{(XW-W){1'b0}}, dead_r});
  assign pos_s  = $signed({{(XW-W){1'b0}}, pos});
  assign edge_s = mid_s - duty_s;
  assign hi_th  = edge_s + dt_s;
  assign lo_th  = edge_s - dt_s;

  assign hi_on   = run && (pos_s >= hi_th);
  assign lo_on   = run && (pos_s <  lo_th);
  assign hi_n_o  = !hi_on;
  assign lo_n_o  = !lo_on;
  assign phase_o = run && ph;

  // R5
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_n_o || lo_n_o);

  // R8
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (hi_n_o && lo_n_o && !phase_o));

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !start) |=> ($stable(duty_r) && $stable(per_r) && $stable(dead_r)));

  // R2
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pos < per_r));

  // R2
  half_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && run && !ph && pos == per_r - 1'b1) |=> (phase_o && $stable(pos)));
endmodule

// File: tb/cpwm_pair_bench.sv
module cpwm_pair_bench;
  localparam int W = 12;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [W-1:0] period_i = '0, dead_i = '0;
  logic signed [W:0] duty_i = '0;
  logic hi_n_o, lo_n_o, phase_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cpwm_pair #(.W(W)) u_cpwm_pair (.clk(clk), .rst_n(rst_n), .en(en), .period_i(period_i),
    .duty_i(duty_i), .dead_i(dead_i), .hi_n_o(hi_n_o), .lo_n_o(lo_n_o), .phase_o(phase_o));

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int posof(int k, int p);
    return (k < p) ? k : 2*p-1-k;
  endfunction

  task automatic launch(int p, int d, int dt);
    en = 0; period_i = W'(p); duty_i = (W+1)'(d); dead_i = W'(dt);
    @(negedge clk); @(negedge clk);
    en = 1;
    @(negedge clk);
  endtask

  task automatic run_case(int p, int d, int dt);
    int eh = 0, el = 0, ep = 0, ov = 0, asym = 0;
    int ah = 0, xh = 0;
    logic hv [0:255];
    logic lv [0:255];
    launch(p, d, dt);
    for (int j = 0; j < 4*p; j++) begin
      int k = j % (2*p);
      int ps = posof(k, p);
      logic xhi = !(ps >= p/2 - d + dt);
      logic xlo = !(ps <  p/2 - d - dt);
      if (hi_n_o !== xhi) begin eh++; ah = hi_n_o; xh = xhi; end
      if (lo_n_o !== xlo) el++;
      if (phase_o !== (k >= p)) ep++;
      if (!hi_n_o && !lo_n_o) ov++;
      if (j < 2*p) begin hv[k] = hi_n_o; lv[k] = lo_n_o; end
      @(negedge clk);
    end
    for (int k = 0; k < p; k++)
      if (hv[k] !== hv[2*p-1-k] || lv[k] !== lv[2*p-1-k]) asym++;
    check(eh == 0, "R3 high-side edge", ah, xh);
    check(el == 0, "R4 low-side edge mismatches", el, 0);
    check(ep == 0, "R2 phase mismatches", ep, 0);
    check(ov == 0, "R5 overlap cycles", ov, 0);
    check(asym == 0, "R9 asymmetric ticks", asym, 0);
  endtask

  task automatic sat_case(int p, int d, int dt, bit hi_full);
    int hon = 0, lon = 0;
    launch(p, d, dt);
    for (int j = 0; j < 4*p; j++) begin
      if (!hi_n_o) hon++;
      if (!lo_n_o) lon++;
      @(negedge clk);
    end
    check(hon == (hi_full ? 4*p : 0), "R6 high on-ticks", hon, hi_full ? 4*p : 0);
    check(lon == (hi_full ? 0 : 4*p), "R6 low on-ticks", lon, hi_full ? 0 : 4*p);
  endtask

  task automatic update_case(int p, int d1, int d2, int dt);
    int err = 0;
    launch(p, d1, dt);
    for (int j = 0; j < 4*p; j++) begin
      int k = j % (2*p);
      int ps = posof(k, p);
      int d = (j < 2*p) ? d1 : d2;
      if (j == p) duty_i = (W+1)'(d2);
      if (hi_n_o !== !(ps >= p/2 - d + dt) || lo_n_o !== !(ps < p/2 - d - dt)) err++;
      @(negedge clk);
    end
    check(err == 0, "R7 mid-period duty change mismatches", err, 0);
  endtask

  task automatic idle_case();
    int bad_idle = 0;
    launch(16, 0, 1);
    repeat (5) @(negedge clk);
    en = 0;
    @(negedge clk);
    for (int j = 0; j < 6; j++) begin
      if (!(hi_n_o && lo_n_o && !phase_o)) bad_idle++;
      @(negedge clk);
    end
    check(bad_idle == 0, "R8 disable hold violations", bad_idle, 0);
    bad_idle = 0;
    period_i = '0; en = 1;
    @(negedge clk);
    for (int j = 0; j < 10; j++) begin
      if (!(hi_n_o && lo_n_o && !phase_o)) bad_idle++;
      @(negedge clk);
    end
    check(bad_idle == 0, "R8 zero-period hold violations", bad_idle, 0);
  endtask

  initial begin
    @(negedge clk);
    check(hi_n_o && lo_n_o && !phase_o, "R1 reset outputs",
          int'({hi_n_o, lo_n_o, phase_o}), 6);
    @(negedge clk);
    rst_n = 1;
    run_case(20, 0, 0);
    run_case(20, 4, 2);
    run_case(21, -3, 1);
    run_case(16, 7, 3);
    run_case(12, -8, 2);
    run_case(7, 1, 0);
    sat_case(20, 10 + 3 + 1, 3, 1'b1);
    sat_case(20, -(10 + 3 + 1), 3, 1'b0);
    sat_case(20, 12, 2, 1'b1);
    update_case(20, 3, -4, 2);
    idle_case();
    run_case(10, 2, 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule